// File: doc/BRIEF.md
# Tick-Driven Reload Timer with Two-Strike Watchdog

This block is a programmable down-counter that advances only on cycles where a 1 MHz tick enable is high. Software loads a control word. That word holds a run bit, an auto-reload bit and a 29-bit reload count. When the counter reaches zero on a tick, the block raises a level interrupt. In auto-reload mode it then starts again from the reload value. In single-shot mode it stops and holds zero.

A companion status word returns the live count and the pending interrupt. Writing it with the clear bit set drops the interrupt. The count bits in that word cannot be written.

The same counter also acts as a watchdog. Each expiry leaves an outstanding debt. A read of the control word pays that debt off. If an expiry occurs while the debt from the previous expiry is still unpaid, the block emits a one-cycle reset request. Software therefore programs half the wanted timeout, minus one. To fully service an expiry, software writes the clear bit and then reads the control word. Writing zeros to the control word stops the counter and disarms the watchdog.

Top module: `tick_wdt_timer`

## Requirements
- R1: After reset the control readback, the status readback, `irq` and `wdt_rst_req` are all zero.
- R2: A write with `wr_sel`=0 loads the control word: bit 31 is run, bit 30 is auto-reload, bits 28:0 are the reload count. The count restarts at that reload value on the next cycle. Reading with `rd_sel`=0 returns run at bit 31, auto-reload at bit 30, zeros at bit 29 and the reload count at bits 28:0.
- R3: While run is set, the count drops by one on each cycle with `tick` high. It does not change when `tick` is low or run is clear.
- R4: A reload count of N gives an expiry on the (N+1)th tick after loading. The expiry happens on the tick seen with count 0. `irq` rises on the following cycle.
- R5: In auto-reload mode an expiry sets the count back to the reload value and leaves run set.
- R6: In single-shot mode an expiry clears run and the count stays 0 with no further expiry.
- R7: Reading with `rd_sel`=1 returns the count at bits 28:0 and the pending interrupt at bit 30. A status write never changes the count.
- R8: A status write (`wr_sel`=1) with bit 30 set clears `irq`. With bit 30 clear it has no effect. An expiry in the same cycle as a clear leaves `irq` set.
- R9: `wdt_rst_req` pulses high for one cycle after an expiry when the previous expiry has not been followed by a control read. The first expiry after a control write never trips.
- R10: A control read (`rd_en` with `rd_sel`=0) pays off the outstanding debt. A read in the same cycle as an expiry pays off the previous debt, so no trip occurs.
- R11: Any control write clears the debt. Writing zero to both words stops counting, so no expiry and no trip follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 1 MHz count enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (control reads kick the watchdog) |
| rd_sel | input | 1 | Read target: 0 control, 1 status |
| rd_data | output | 32 | Readback of the selected word |
| irq | output | 1 | Level interrupt, held until cleared |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The bench targets the following corner cases, and names the failure each one would expose:

- **Off-by-one period.** A design that expires on the Nth tick, or one tick late, shows `irq` at the wrong step.
- **Single-shot stop.** A timer that fails to clear run keeps expiring.
- **Two-strike watchdog.** A watchdog that trips on the first expiry, or ignores the missing control read, gives a wrong `wdt_rst_req`. So does one whose request lasts more than a cycle.
- **Same-cycle collisions.** These are an expiry against a clear write, and an expiry against a kick read. A wrong priority here shows up as a lost interrupt or a false reset request.
- **Inert writes.** These are a status write without the clear bit, and a zeroed control word. A design that lets either touch the count or the watchdog fails the readback and pulse checks.

// File: rtl/tick_wdt_pkg.sv
package tick_wdt_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 29;
  localparam int RUN_BIT = 31;
  localparam int AUTO_BIT = 30;
  localparam int ACK_BIT = 30;
  localparam int PEND_BIT = 30;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic              run;
    logic              auto_rl;
    logic [CNT_W-1:0]  reload;
  } ctl_t;
endpackage

// File: rtl/tick_wdt_ctl.sv
module tick_wdt_ctl
  import tick_wdt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  ctl_t  load_word,
  input  logic  expire,
  output ctl_t  ctl
);
  ctl_t ctl_nxt;
  logic ctl_ce;

  always_comb begin
    ctl_nxt = ctl;
    ctl_ce  = 1'b0;
    if (load) begin
      ctl_nxt = load_word;
      ctl_ce  = 1'b1;
    end else if (expire && !ctl.auto_rl) begin
      ctl_nxt.run = 1'b0;
      ctl_ce      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else if (ctl_ce) ctl <= ctl_nxt;
  end

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctl.auto_rl) |=> !ctl.run) else $error("one-shot kept running"); // R6
  AST_AUTO_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctl.auto_rl) |=> ctl.run) else $error("auto-reload stopped"); // R5
endmodule

// File: rtl/tick_wdt_count.sv
module tick_wdt_count
  import tick_wdt_pkg::*;
#(
  parameter int W = CNT_W
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         auto_rl,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] count_nxt;
  logic         at_zero;
  logic         step_en;
  logic         cnt_ce;

  always_comb begin
    at_zero   = (count == '0);
    step_en   = tick && run && !load;
    expire    = step_en && at_zero;
    cnt_ce    = load || step_en;
    count_nxt = count;
    if (load)
      count_nxt = load_val;
    else if (step_en)
      count_nxt = at_zero ? (auto_rl ? reload : '0) : (count - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (cnt_ce) count <= count_nxt;
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(tick && run)) |=> $stable(count)) else $error("count moved while idle"); // R3
  AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && auto_rl) |=> (count == $past(reload))) else $error("no reload"); // R5
  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val))) else $error("write did not restart"); // R2
endmodule

// File: rtl/tick_wdt_dog.sv
module tick_wdt_dog (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack_wr,
  input  logic kick,
  input  logic restart,
  output logic irq,
  output logic rst_req
);
  logic owed;
  logic irq_nxt, owed_nxt, trip;

  always_comb begin
    trip    = expire && owed && !kick;
    irq_nxt = irq;
    if (expire)      irq_nxt = 1'b1;
    else if (ack_wr) irq_nxt = 1'b0;
    owed_nxt = owed;
    if (restart)     owed_nxt = 1'b0;
    else if (expire) owed_nxt = 1'b1;
    else if (kick)   owed_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      owed    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      irq     <= irq_nxt;
      owed    <= owed_nxt;
      rst_req <= trip;
    end
  end

  AST_EXPIRY_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq) else $error("expiry lost"); // R8
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !expire) |=> !irq) else $error("clear ignored"); // R8
  AST_TRIP_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> irq) else $error("reset request without expiry"); // R9
  AST_KICK_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !rst_req) else $error("tripped despite kick"); // R10
  AST_RESTART_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !rst_req) else $error("tripped on control write"); // R11
endmodule

// File: rtl/tick_wdt_timer.sv
module tick_wdt_timer
  import tick_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              wdt_rst_req
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe[SYNC_STAGES-1];

  ctl_t             ctl;
  ctl_t             load_word;
  logic [CNT_W-1:0] count;
  logic             load, ack_wr, kick, expire;
  logic             unused_bits;

  always_comb begin
    load              = wr_en && !wr_sel;
    ack_wr            = wr_en && wr_sel && wr_data[ACK_BIT];
    kick              = rd_en && !rd_sel;
    load_word.run     = wr_data[RUN_BIT];
    load_word.auto_rl = wr_data[AUTO_BIT];
    load_word.reload  = wr_data[CNT_W-1:0];
  end
  assign unused_bits = ^wr_data[RUN_BIT-2:CNT_W];

  tick_wdt_ctl u_ctl (
    .clk(clk), .rst_n(rst_n_int), .load(load), .load_word(load_word),
    .expire(expire), .ctl(ctl)
  );

  tick_wdt_count #(.W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n_int), .tick(tick), .run(ctl.run),
    .auto_rl(ctl.auto_rl), .load(load), .load_val(load_word.reload),
    .reload(ctl.reload), .count(count), .expire(expire)
  );

  tick_wdt_dog u_dog (
    .clk(clk), .rst_n(rst_n_int), .expire(expire), .ack_wr(ack_wr),
    .kick(kick), .restart(load), .irq(irq), .rst_req(wdt_rst_req)
  );

  always_comb begin
    rd_data = '0;
    if (rd_sel) begin
      rd_data[CNT_W-1:0] = count;
      rd_data[PEND_BIT]  = irq;
    end else begin
      rd_data[CNT_W-1:0] = ctl.reload;
      rd_data[AUTO_BIT]  = ctl.auto_rl;
      rd_data[RUN_BIT]   = ctl.run;
    end
  end

  AST_STATUS_WRITE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_en && wr_sel && !(tick && ctl.run)) |=> $stable(count)) else $error("status write hit count"); // R7
  AST_IDLE_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n_int)
    !ctl.run |-> !expire) else $error("expiry while stopped"); // R11
endmodule

// File: tb/tick_wdt_timer_tb.sv
module tick_wdt_timer_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  MAX_CYCLES = 150000;

  logic        clk, rst_n, tick, wr_en, wr_sel, rd_en, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic        irq, wdt_rst_req;

  int checks = 0;
  int errors = 0;

  logic        m_run, m_auto, m_irq, m_owed, m_rst;
  logic [28:0] m_rel, m_cnt;

  tick_wdt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq(irq), .wdt_rst_req(wdt_rst_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ctl_word(logic r, logic a, logic [28:0] n);
    return {r, a, 1'b0, n};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic we, logic ws, logic [31:0] wd, logic re, logic rs, logic tk);
    logic load, ack, kick, ex;
    logic [28:0] c_n;
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_data = wd; rd_en = re; rd_sel = rs; tick = tk;
    load = we && !ws;
    ack  = we && ws && wd[30];
    kick = re && !rs;
    ex   = tk && m_run && !load && (m_cnt == 0);
    c_n  = m_cnt;
    if (load) c_n = wd[28:0];
    else if (tk && m_run) c_n = (m_cnt == 0) ? (m_auto ? m_rel : 29'd0) : m_cnt - 29'd1;
    m_rst = ex && m_owed && !kick;
    if (ex) m_irq = 1'b1; else if (ack) m_irq = 1'b0;
    if (load) m_owed = 1'b0; else if (ex) m_owed = 1'b1; else if (kick) m_owed = 1'b0;
    if (load) begin m_run = wd[31]; m_auto = wd[30]; m_rel = wd[28:0]; end
    else if (ex && !m_auto) m_run = 1'b0;
    m_cnt = c_n;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0;
    rd_sel = 1'b1; #1;
    chk("R3/R7 status readback", rd_data, {1'b0, m_irq, 1'b0, m_cnt});
    rd_sel = 1'b0; #1;
    chk("R2 control readback", rd_data, ctl_word(m_run, m_auto, m_rel));
    chk("R8 irq level", {31'd0, irq}, {31'd0, m_irq});
    chk("R9 reset request", {31'd0, wdt_rst_req}, {31'd0, m_rst});
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_run = 0; m_auto = 0; m_irq = 0; m_owed = 0; m_rst = 0; m_rel = 0; m_cnt = 0;
    rst_n = 1'b0; tick = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_en = 0; rd_sel = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    rd_sel = 1'b0; #1 chk("R1 control after reset", rd_data, 32'd0);
    rd_sel = 1'b1; #1 chk("R1 status after reset", rd_data, 32'd0);
    chk("R1 outputs after reset", {30'd0, irq, wdt_rst_req}, 32'd0);

    // R4/R5: reload 3, auto-reload -> expiry on 4th tick
    step(1'b1, 1'b0, ctl_word(1, 1, 29'd3), 1'b0, 1'b0, 1'b0);
    ticks(3);
    chk("R4 no irq before N+1 ticks", {31'd0, irq}, 32'd0);
    ticks(1);
    chk("R4 irq after N+1 ticks", {31'd0, irq}, 32'd1);
    rd_sel = 1'b1; #1 chk("R5 count reloaded", rd_data[28:0], 29'd3);
    chk("R9 first expiry no trip", {31'd0, wdt_rst_req}, 32'd0);
    // R8: clear bit absent has no effect; present clears
    step(1'b1, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    chk("R8 status write w/o clear bit", {31'd0, irq}, 32'd1);
    step(1'b1, 1'b1, 32'h1FFF_FFFF, 1'b0, 1'b0, 1'b0);
    rd_sel = 1'b1; #1 chk("R7 count bits read-only", rd_data[28:0], 29'd3);
    step(1'b1, 1'b1, 32'h4000_0000, 1'b0, 1'b0, 1'b0);
    chk("R8 clear bit drops irq", {31'd0, irq}, 32'd0);
    // R9: no kick -> second expiry trips, one cycle only
    ticks(4);
    chk("R9 second unpaid expiry trips", {31'd0, wdt_rst_req}, 32'd1);
    step(1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);
    chk("R9 pulse is one cycle", {31'd0, wdt_rst_req}, 32'd0);
    // R10: kick then next expiry no trip
    step(1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0);
    ticks(4);
    chk("R10 kicked expiry no trip", {31'd0, wdt_rst_req}, 32'd0);
    // R10: kick in same cycle as expiry
    ticks(3);
    step(1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b1);
    chk("R10 same-cycle kick", {31'd0, wdt_rst_req}, 32'd0);
    // R8: clear in same cycle as expiry keeps irq
    ticks(3);
    step(1'b1, 1'b1, 32'h4000_0000, 1'b1, 1'b0, 1'b1);
    chk("R8 expiry beats clear", {31'd0, irq}, 32'd1);
    // R6: single-shot
    step(1'b1, 1'b0, ctl_word(1, 0, 29'd2), 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 32'h4000_0000, 1'b0, 1'b0, 1'b0);
    ticks(3);
    rd_sel = 1'b0; #1 chk("R6 run cleared", rd_data, ctl_word(0, 0, 29'd2));
    step(1'b1, 1'b1, 32'h4000_0000, 1'b0, 1'b0, 1'b0);
    ticks(5);
    chk("R6 no further expiry", {31'd0, irq}, 32'd0);
    rd_sel = 1'b1; #1 chk("R6 count holds zero", rd_data[28:0], 29'd0);
    // R11: owe a debt, then zero both words
    step(1'b1, 1'b0, ctl_word(1, 1, 29'd1), 1'b0, 1'b0, 1'b0);
    ticks(2);
    step(1'b1, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 32'd0, 1'b0, 1'b0, 1'b0);
    ticks(10);
    chk("R11 stopped, no trip", {30'd0, irq, wdt_rst_req}, 32'd2);
    rd_sel = 1'b1; #1 chk("R11 count frozen", rd_data[28:0], 29'd0);
    // random phase (R2..R10 via model)
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0)
        step(1'b1, 1'b0, ctl_word(r[8:4] != 0, r[9], 29'(r[12:10])), 1'b0, 1'b0, r[13]);
      else if (r[3:0] == 4'd1)
        step(1'b1, 1'b1, {1'b0, r[14], 1'b0, 29'(r[31:15])}, r[16], r[17], r[13]);
      else
        step(1'b0, 1'b0, 32'd0, r[4:0] == 5'd2, r[18], r[13] | r[19]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule